// File: doc/BRIEF.md
# Triangle-Carrier PWM Generator

This block turns an 8-bit duty value into a pair of complementary pulse-width-modulated bits. It compares the duty value with a carrier that runs freely up and down as a symmetric triangle. The duty value reaches the block as a field of a 32-bit instruction word, offered on a valid/ready stream. Only words with the PWM opcode change the duty value. A new duty value is held back until the carrier next sits at zero, so no carrier period runs with two different duty values.

The two pulse bits are packed into a 28-bit result word at fixed positions. The current carrier value is also output so that it can be observed. The instruction stream never pushes back: `instr_ready` is always high. The block therefore accepts every word that arrives with `instr_valid` high, and if several PWM words arrive before the carrier reaches zero, the last of them wins. The duty value last applied stays in force until a new PWM word is accepted.

Top module: `tripwm_top`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets the carrier to 0, its direction to up, and both the pending and the applied duty to 0. In the cycle after reset, `carrier_o` is 0 and `result_o` is 0x4000000, which is bit 26 alone.
- R2: After reset the carrier steps by one each clock. It goes 0, 1, …, 255 and then 254, …, 1, and then returns to 0. Each end value lasts a single cycle, so the period is 510 clocks.
- R3: The first pulse bit (`result_o[27]`) is high exactly when the applied duty is greater than the current carrier value.
- R4: The second pulse bit (`result_o[26]`) is always the inverse of the first.
- R5: `result_o[25:0]` is always zero.
- R6: An accepted word whose bits 4:0 equal 5'b11010 loads bits 12:5 as the pending duty. An accepted word with any other value in bits 4:0 changes nothing at the outputs.
- R7: The pending duty becomes the applied duty only at a clock edge where the carrier reads 0. A word accepted in that same cycle is applied at that edge.
- R8: With a duty of 0 the first pulse bit stays low for the whole period. With a duty of 255 it is high in 509 of the 510 cycles and low only at the peak.
- R9: `instr_ready` is always 1. When several PWM words are accepted before the carrier reaches 0, only the last one is applied.
- R10: The applied duty is kept across any number of periods until another PWM word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction word is offered |
| instr_ready | output | 1 | Always high; the block accepts every offered word |
| instr_data | input | 32 | Instruction word: opcode in 4:0, duty in 12:5 |
| carrier_o | output | 8 | Current triangle carrier value |
| result_o | output | 28 | Result word: first pulse bit in bit 27, its inverse in bit 26, zeros elsewhere |

## Verification
A wrong direction bit or counter value shows on `carrier_o` in the very next cycle: the value either leaves the 0..255..1 sequence or turns at the wrong end. Because the pulse bits depend on the carrier, the error then moves the pulse edges within the same period. A wrong applied duty shows in the first cycle where the carrier lies between the right duty and the wrong one, which means within one period. A duty that is applied at the wrong moment shows as a pulse edge in the period before the carrier reaches zero. The bench's model predicts the carrier and both pulse bits for every cycle, so each of these faults is caught in the cycle where it first becomes visible.

// File: rtl/tripwm_pkg.sv
package tripwm_pkg;
  localparam int INSTR_W  = 32;
  localparam int OPC_LSB  = 0;
  localparam int OPC_W    = 5;
  localparam logic [OPC_W-1:0] OPC_PWM = 5'b11010;
  localparam int DUTY_LSB = 5;
  localparam int RES_W    = 28;
  localparam int BIT_HI   = 27;
  localparam int BIT_LO   = 26;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/tripwm_carrier.sv
module tripwm_carrier #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] car_o,
  output logic         at_zero_o
);
  import tripwm_pkg::*;
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] NEAR = TOP - 1'b1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  dir_e         dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + ONE;
      if (cnt_q == NEAR) dir_q <= DIR_DOWN;
    end else begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) dir_q <= DIR_UP;
    end
  end

  assign car_o     = cnt_q;
  assign at_zero_o = (cnt_q == '0);
endmodule

// File: rtl/tripwm_duty.sv
module tripwm_duty #(
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [tripwm_pkg::INSTR_W-1:0] in_data,
  input  logic                          apply_now,
  output logic [W-1:0]                  duty_o
);
  import tripwm_pkg::*;

  logic [W-1:0] pend_q, act_q, pend_nx;
  logic         hit;

  always_comb begin
    hit     = in_valid && (in_data[OPC_LSB +: OPC_W] == OPC_PWM);
    pend_nx = hit ? in_data[DUTY_LSB +: W] : pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_nx;
      if (apply_now) act_q <= pend_nx;
    end
  end

  assign duty_o = act_q;
endmodule

// File: rtl/tripwm_cmp.sv
module tripwm_cmp #(
  parameter int W    = 8,
  parameter int OUTS = 2
) (
  input  logic [W-1:0]    duty,
  input  logic [W-1:0]    car,
  output logic [OUTS-1:0] pulse_o
);
  logic above;
  assign above = duty > car;

  for (genvar k = 0; k < OUTS; k++) begin : g_out
    if (k % 2 == 0) begin : g_true
      assign pulse_o[k] = above;
    end else begin : g_inv
      assign pulse_o[k] = ~above;
    end
  end
endmodule

// File: rtl/tripwm_top.sv
module tripwm_top #(
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          instr_valid,
  output logic                          instr_ready,
  input  logic [tripwm_pkg::INSTR_W-1:0] instr_data,
  output logic [W-1:0]                  carrier_o,
  output logic [tripwm_pkg::RES_W-1:0]  result_o
);
  import tripwm_pkg::*;

  logic [W-1:0] car, duty_act;
  logic         zero;
  logic [1:0]   pulse;

  tripwm_carrier #(.W(W)) car_i (
    .clk(clk), .rst(rst), .car_o(car), .at_zero_o(zero)
  );

  tripwm_duty #(.W(W)) duty_i (
    .clk(clk), .rst(rst), .in_valid(instr_valid), .in_data(instr_data),
    .apply_now(zero), .duty_o(duty_act)
  );

  tripwm_cmp #(.W(W), .OUTS(2)) cmp_i (
    .duty(duty_act), .car(car), .pulse_o(pulse)
  );

  always_comb begin
    result_o         = '0;
    result_o[BIT_HI] = pulse[0];
    result_o[BIT_LO] = pulse[1];
  end

  assign instr_ready = 1'b1;
  assign carrier_o   = car;
endmodule

// File: rtl/tripwm_chk.sv
module tripwm_chk #(
  parameter int W = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic [W-1:0]                  carrier_o,
  input logic [tripwm_pkg::RES_W-1:0]  result_o,
  input logic [W-1:0]                  duty_act,
  input logic                          instr_ready
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  a_r2_peak_turn: assert property (@(posedge clk) disable iff (rst)
    carrier_o == TOP |=> carrier_o == TOP - 1'b1);
  a_r2_floor_turn: assert property (@(posedge clk) disable iff (rst)
    carrier_o == '0 |=> carrier_o == {{(W-1){1'b0}}, 1'b1});
  a_r4_complement: assert property (@(posedge clk) disable iff (rst)
    result_o[27] != result_o[26]);
  a_r5_zero_field: assert property (@(posedge clk) disable iff (rst)
    result_o[25:0] == '0);
  a_r7_hold_midperiod: assert property (@(posedge clk) disable iff (rst)
    carrier_o != '0 |=> $stable(duty_act));
  a_r8_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
    duty_act == '0 |-> !result_o[27]);
  a_r9_ready: assert property (@(posedge clk) disable iff (rst)
    instr_ready);
endmodule

bind tripwm_top tripwm_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .carrier_o(carrier_o), .result_o(result_o),
  .duty_act(duty_act), .instr_ready(instr_ready)
);

// File: tb/tripwm_top_tb_top.sv
module tripwm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_data = '0;
  logic [7:0]  carrier_o;
  logic [27:0] result_o;

  int checks = 0;
  int errors = 0;

  int m_n = 0;
  int m_pend = 0;
  int m_act = 0;

  always #2.5 clk = ~clk;

  tripwm_top dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_data(instr_data), .carrier_o(carrier_o), .result_o(result_o)
  );

  function automatic int car_of(int n);
    int p;
    p = n % 510;
    return (p <= 255) ? p : 510 - p;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at n=%0d", req, act, exp, m_n);
    end
  endtask

  // one cycle: inputs already set; model follows the edge, then compare at negedge
  task automatic cycle();
    int nxp;
    @(posedge clk);
    if (rst) begin
      m_n = 0; m_pend = 0; m_act = 0;
    end else begin
      nxp = (instr_valid && instr_data[4:0] == 5'b11010) ? int'(instr_data[12:5]) : m_pend;
      if (car_of(m_n) == 0) m_act = nxp;
      m_pend = nxp;
      m_n++;
    end
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R2 carrier", int'(carrier_o), car_of(m_n));
    chk("R3 first pulse bit", int'(result_o[27]), (m_act > car_of(m_n)) ? 1 : 0);
    chk("R4 second pulse bit", int'(result_o[26]), (m_act > car_of(m_n)) ? 0 : 1);
    chk("R5 unused bits", int'(result_o[25:0]), 0);
    chk("R9 ready", int'(instr_ready), 1);
  endtask

  task automatic send(int opc, int duty);
    instr_valid = 1'b1;
    instr_data  = 32'hA000_0000 | (32'(duty) << 5) | 32'(opc);
    cycle();
  endtask

  task automatic run(int k);
    for (int i = 0; i < k; i++) cycle();
  endtask

  task automatic wait_zero();
    while (car_of(m_n) != 0) cycle();
  endtask

  initial begin
    #250000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int highs;
    @(negedge clk);
    run(3);
    rst = 1'b0;
    // R1: after reset state
    chk("R1 carrier after reset", int'(carrier_o), 0);
    chk("R1 result after reset", int'(result_o), 28'h400_0000);
    // R8: duty 0 stays low for a full period
    highs = 0;
    for (int i = 0; i < 510; i++) begin cycle(); highs += int'(result_o[27]); end
    chk("R8 duty 0 high count", highs, 0);
    // R2: period of 510
    chk("R2 carrier at period end", int'(carrier_o), 0);
    // R7: load mid-period, check not applied before zero
    run(40);
    send(5'b11010, 100);
    run(100);
    chk("R7 no mid-period apply", int'(result_o[27]), 0);
    wait_zero();
    run(50);
    chk("R7 applied after zero", int'(result_o[27]), 1);
    // R6: other opcode ignored
    send(5'b11011, 200);
    wait_zero();
    run(150);
    chk("R6 other opcode ignored", int'(result_o[27]), 0);
    // R9: last of several wins
    send(5'b11010, 10);
    send(5'b11010, 240);
    wait_zero();
    run(200);
    chk("R9 last word wins", int'(result_o[27]), 1);
    // R7: word accepted at the carrier-zero cycle applies at once
    wait_zero();
    send(5'b11010, 255);
    highs = int'(result_o[27]);
    for (int i = 1; i < 510; i++) begin cycle(); highs += int'(result_o[27]); end
    chk("R8 duty 255 high count", highs, 509);
    // R10: duty held over several periods
    run(1530);
    highs = 0;
    for (int i = 0; i < 510; i++) begin cycle(); highs += int'(result_o[27]); end
    chk("R10 duty kept", highs, 509);
    // R1: reset mid-run
    run(77);
    rst = 1'b1;
    cycle();
    rst = 1'b0;
    chk("R1 carrier after second reset", int'(carrier_o), 0);
    chk("R1 result after second reset", int'(result_o), 28'h400_0000);
    run(600);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule